// File: doc/BRIEF.md
# Doubleword Burst DMA Slave Data Path

This block is the data path of a bus DMA slave. It moves 32-bit doublewords between a system bus and a device-side FIFO during burst transfers. A transfer is set up with a doubleword count and a direction. From then on the block moves one doubleword on every bus clock in which the bus acknowledges the burst, the bus is ready, and the FIFO can take or give a whole doubleword. When the bus asks for a wait state, nothing moves and the current doubleword stays where it is.

Every transfer is assumed to be doubleword aligned. Stray bytes at either end of a buffer (up to three at the head and three at the tail) are left to the processor, which moves them through ordinary I/O accesses to the data register. The block only watches those I/O strobes so that it can flag a strobe seen in the middle of a burst. Bus arbitration is not part of this block.

Top module: `dw_burst_slave`

## Requirements
- R1: After reset, `busy`, `dma_req`, `fifo_push`, `fifo_pop` and `strobe_err` are all 0, and `bus_rdata` is 0.
- R2: A `start` sampled high while idle with a nonzero `start_count` makes `busy` high after that clock edge. A `start` with `start_count` of 0 is ignored. A `start` while `busy` is high is ignored and does not reload the count.
- R3: In direction 0 (bus to device), `fifo_push` is high in exactly the clocks where `busy`, `dma_ack`, `bus_rdy` and `fifo_space` are all high, and `fifo_wdata` equals `bus_wdata`. `fifo_pop` stays low.
- R4: In direction 1 (device to bus), `fifo_pop` is high in exactly the clocks where `busy`, `dma_ack`, `bus_rdy` and `fifo_avail` are all high, and `bus_rdata` equals `fifo_rdata`. `bus_rdata` is 0 when no read burst is active, and `fifo_push` stays low.
- R5: When the bus and the FIFO stay ready, a burst of N doublewords completes in N consecutive clocks, with one transfer on each clock.
- R6: While `bus_rdy` is low, neither `fifo_push` nor `fifo_pop` is asserted and the remaining count is held, so the burst lasts one clock longer for each wait clock.
- R7: `dma_req` is high exactly when `busy` is high and the FIFO can serve one doubleword in the latched direction (`fifo_avail` for direction 1, `fifo_space` for direction 0).
- R8: `busy` falls on the clock edge of the N-th transfer. After that, no push or pop occurs even if `dma_ack` and `bus_rdy` stay high.
- R9: An `io_rd` or `io_wr` sampled high while `busy` and `dma_ack` are high sets `strobe_err`. The flag stays set until the next accepted `start` clears it. A strobe while idle leaves it at 0.
- R10: The direction is latched when a start is accepted. Changing `start_dir` during a burst has no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a burst transfer |
| start_count | input | CNT_W | Number of doublewords to move |
| start_dir | input | 1 | 0 = bus to device, 1 = device to bus |
| dma_ack | input | 1 | Bus grants the burst this clock |
| bus_rdy | input | 1 | Bus ready; low requests a wait state |
| io_rd | input | 1 | Processor I/O read strobe |
| io_wr | input | 1 | Processor I/O write strobe |
| bus_wdata | input | DW | Doubleword from the bus |
| bus_rdata | output | DW | Doubleword to the bus |
| dma_req | output | 1 | Request to the bus for the next doubleword |
| busy | output | 1 | Burst in progress |
| strobe_err | output | 1 | Sticky flag: I/O strobe seen during a burst |
| fifo_space | input | 1 | FIFO can accept a doubleword |
| fifo_push | output | 1 | Write one doubleword to the FIFO |
| fifo_wdata | output | DW | Doubleword written to the FIFO |
| fifo_avail | input | 1 | FIFO holds at least one doubleword |
| fifo_pop | output | 1 | Take one doubleword from the FIFO |
| fifo_rdata | input | DW | Head doubleword of the FIFO |

## Verification
The bench drives the main transfer function with four input patterns:
- A fully ready write burst tells the one-per-clock rate apart from any design that inserts a gap between transfers.
- A write burst with `bus_rdy` and `fifo_space` dropped in separate clocks shows that the two stall sources each gate the transfer on their own. It also shows that the count is held rather than consumed while stalled.
- A read burst with gaps in `fifo_avail` checks that `dma_req`, the pop and the data passthrough all follow FIFO readiness.
- A read burst during which the direction input flips and a second start arrives checks that the latched direction and the latched count both survive.

// File: rtl/dw_burst_slave.sv
module dw_burst_slave #(
  parameter int DW    = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] start_count,
  input  logic             start_dir,
  input  logic             dma_ack,
  input  logic             bus_rdy,
  input  logic             io_rd,
  input  logic             io_wr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             dma_req,
  output logic             busy,
  output logic             strobe_err,
  input  logic             fifo_space,
  output logic             fifo_push,
  output logic [DW-1:0]    fifo_wdata,
  input  logic             fifo_avail,
  output logic             fifo_pop,
  input  logic [DW-1:0]    fifo_rdata
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             busy_q, dir_q, err_q;
  logic [CNT_W-1:0] left_q;

  wire fifo_ok = dir_q ? fifo_avail : fifo_space;
  wire xfer    = busy_q & dma_ack & bus_rdy & fifo_ok;
  wire accept  = start & ~busy_q & (start_count != '0);
  wire strobe  = busy_q & dma_ack & (io_rd | io_wr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      dir_q  <= 1'b0;
      err_q  <= 1'b0;
      left_q <= '0;
    end else begin
      if (accept) begin
        busy_q <= 1'b1;
        dir_q  <= start_dir;
        left_q <= start_count;
        err_q  <= 1'b0;
      end else begin
        if (xfer) begin
          left_q <= left_q - ONE;
          if (left_q == ONE) busy_q <= 1'b0;
        end
        if (strobe) err_q <= 1'b1;
      end
    end
  end

  assign busy       = busy_q;
  assign strobe_err = err_q;
  assign dma_req    = busy_q & fifo_ok;
  assign fifo_push  = xfer & ~dir_q;
  assign fifo_pop   = xfer & dir_q;
  assign fifo_wdata = bus_wdata;
  assign bus_rdata  = (busy_q & dir_q) ? fifo_rdata : '0;

endmodule

module dw_burst_slave_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [CNT_W-1:0] start_count,
  input logic             bus_rdy,
  input logic             busy,
  input logic             dma_req,
  input logic             strobe_err,
  input logic             fifo_push,
  input logic             fifo_pop
);

  logic [CNT_W-1:0] exp_left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) exp_left <= '0;
    else if (start && !busy && start_count != '0) exp_left <= start_count;
    else if ((fifo_push || fifo_pop) && exp_left != '0) exp_left <= exp_left - CNT_W'(1);
  end

  a_r8_busy_tracks_count: assert property (@(posedge clk) disable iff (!rst_n)
    busy == (exp_left != '0));

  a_r6_wait_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rdy |-> !fifo_push && !fifo_pop);

  a_r3_push_pop_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_push && fifo_pop));

  a_r7_move_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_push || fifo_pop) |-> dma_req && busy);

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_err && !(start && !busy) |=> strobe_err);

endmodule

bind dw_burst_slave dw_burst_slave_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .start_count(start_count),
  .bus_rdy(bus_rdy), .busy(busy), .dma_req(dma_req), .strobe_err(strobe_err),
  .fifo_push(fifo_push), .fifo_pop(fifo_pop)
);

// File: tb/dw_burst_slave_tb.sv
`timescale 1ns/1ps
module dw_burst_slave_tb_top;
  localparam int DW = 32, CNT_W = 16;

  logic clk = 0, rst_n = 0;
  logic start = 0, start_dir = 0, dma_ack = 0, bus_rdy = 0, io_rd = 0, io_wr = 0;
  logic [CNT_W-1:0] start_count = '0;
  logic [DW-1:0] bus_wdata = '0, fifo_rdata = '0;
  logic fifo_space = 0, fifo_avail = 0;
  logic [DW-1:0] bus_rdata, fifo_wdata;
  logic dma_req, busy, strobe_err, fifo_push, fifo_pop;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  dw_burst_slave #(.DW(DW), .CNT_W(CNT_W)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic go(input int n, input bit d);
    start = 1; start_count = CNT_W'(n); start_dir = d;
    step();
    start = 0;
  endtask

  task automatic t_reset();
    #1;
    chk(!busy && !dma_req && !fifo_push && !fifo_pop && !strobe_err && bus_rdata == 0,
        "R1 reset outputs", {busy, dma_req, fifo_push, fifo_pop, strobe_err}, 0);
  endtask

  task automatic t_zero_start();
    go(0, 0);
    #1 chk(busy == 0, "R2 zero count ignored", busy, 0);
  endtask

  task automatic t_write_full();
    dma_ack = 1; bus_rdy = 1; fifo_space = 1; fifo_avail = 0;
    go(4, 0);
    for (int i = 0; i < 4; i++) begin
      bus_wdata = 32'hA000_0000 + i;
      #1;
      chk(fifo_push && !fifo_pop, "R5 push each clock", fifo_push, 1);
      chk(fifo_wdata == bus_wdata, "R3 write data", fifo_wdata, bus_wdata);
      step();
    end
    #1;
    chk(busy == 0, "R8 busy falls after count", busy, 0);
    chk(fifo_push == 0, "R8 no push after end", fifo_push, 0);
  endtask

  task automatic t_write_wait();
    bit rdy_p[5] = '{1, 0, 1, 1, 1};
    bit spc_p[5] = '{1, 1, 0, 1, 1};
    dma_ack = 1;
    go(3, 0);
    for (int i = 0; i < 5; i++) begin
      bus_rdy = rdy_p[i]; fifo_space = spc_p[i];
      #1;
      chk(dma_req == spc_p[i], "R7 req follows space", dma_req, spc_p[i]);
      chk(fifo_push == (rdy_p[i] & spc_p[i]), "R6 push gated by wait", fifo_push, rdy_p[i] & spc_p[i]);
      if (i == 4) chk(busy == 1, "R6 count held during wait", busy, 1);
      step();
    end
    #1 chk(busy == 0, "R8 end after three moves", busy, 0);
  endtask

  task automatic t_read_gaps();
    bit av_p[5] = '{1, 0, 1, 1, 1};
    dma_ack = 1; bus_rdy = 1; fifo_space = 0;
    go(4, 1);
    for (int i = 0; i < 5; i++) begin
      fifo_avail = av_p[i]; fifo_rdata = 32'h5500_0000 + i;
      #1;
      chk(dma_req == av_p[i], "R7 req follows avail", dma_req, av_p[i]);
      chk(fifo_pop == av_p[i] && !fifo_push, "R4 pop gated", fifo_pop, av_p[i]);
      chk(bus_rdata == fifo_rdata, "R4 read data", bus_rdata, fifo_rdata);
      step();
    end
    #1;
    chk(busy == 0, "R8 read end", busy, 0);
    chk(bus_rdata == 0, "R4 idle rdata zero", bus_rdata, 0);
  endtask

  task automatic t_dir_latch();
    dma_ack = 1; bus_rdy = 1; fifo_avail = 1; fifo_space = 1;
    go(3, 1);
    start_dir = 0; start = 1; start_count = CNT_W'(9);
    for (int i = 0; i < 3; i++) begin
      #1;
      chk(fifo_pop && !fifo_push, "R10 direction held", fifo_pop, 1);
      step();
      start = 0;
    end
    #1 chk(busy == 0, "R2 restart while busy ignored", busy, 0);
  endtask

  task automatic t_strobe();
    dma_ack = 1; bus_rdy = 0; fifo_space = 1;
    io_wr = 1; step(); io_wr = 0;
    #1 chk(strobe_err == 0, "R9 idle strobe ignored", strobe_err, 0);
    go(2, 0);
    io_rd = 1; step(); io_rd = 0;
    #1 chk(strobe_err == 1, "R9 strobe during burst", strobe_err, 1);
    bus_rdy = 1; step(); step();
    #1 chk(strobe_err == 1 && busy == 0, "R9 flag sticky", strobe_err, 1);
    bus_rdy = 0;
    go(1, 0);
    #1 chk(strobe_err == 0, "R9 cleared by start", strobe_err, 0);
    bus_rdy = 1; step();
  endtask

  initial begin
    t_reset();
    #10 rst_n = 1;
    step();
    t_zero_start();
    t_write_full();
    t_write_wait();
    t_read_gaps();
    t_dir_latch();
    t_strobe();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule